// File: doc/BRIEF.md
# Speculative Reorder Buffer with In-Order Retirement

This block keeps a circular window of in-flight instructions for a speculative out-of-order core. Each instruction is given a slot at issue, in program order, and the slot index serves as its tag. Execution units later broadcast results on a shared result bus together with that tag. The buffer catches these results and holds them until the instruction reaches the oldest position.

Store slots hold two pieces of data. The result bus writes the store's own tag with the effective address. The store data comes from a producer tag that the store records at issue. If that data is not ready at issue, the slot keeps watching the bus for the producer tag. A broadcast of that tag in the same cycle as the issue is also caught.

Retirement is strictly in order, one slot per cycle, and only when the oldest slot is complete. There are three retirement paths:
- An ordinary instruction writes the register file.
- A store writes memory.
- A branch found to be mispredicted empties the whole buffer and requests a restart at the target it reported.

A correctly predicted branch leaves without any side effect.

Top module: `rob_core`

## Requirements
- R1: An accepted issue (iss_valid and iss_ready high at a clock edge) takes the slot shown on iss_tag. Successive accepted issues get tags 0,1,2,… in program order, wrapping from DEPTH-1 to 0.
- R2: iss_ready is low while all DEPTH slots are occupied. It returns high in the cycle after a retirement frees a slot.
- R3: A bus broadcast (cdb_valid) whose tag names an occupied, incomplete slot stores cdb_value and cdb_mispred there and marks it complete. A broadcast naming a free slot leaves no trace: a later issue into that slot stays incomplete.
- R4: The data of a store comes from one of three places: iss_src_val at issue when iss_src_ok is high, a broadcast of iss_src_tag in the issue cycle, or a later broadcast of that tag. The store retires as mem_we with mem_addr equal to its own broadcast value and mem_data equal to the captured data. It retires only once both are present.
- R5: Only the oldest slot may retire, and only once it is complete. A younger complete slot waits, and nothing retires while the buffer is empty.
- R6: iss_kind is 0 for an ordinary instruction, 1 for a store and 2 for a branch. An ordinary instruction retires with a single-cycle rf_we carrying its iss_dest on rf_idx and its value on rf_data. At most one of rf_we, mem_we and flush is high in any cycle.
- R7: A branch whose broadcast had cdb_mispred low retires with rf_we, mem_we and flush all low. The next slot then becomes the oldest.
- R8: A branch whose broadcast had cdb_mispred high raises flush for one cycle when it is the oldest, with redirect_pc equal to its broadcast value. On the following cycle all slots are free and the next issue gets tag 0.
- R9: iss_ready is low in a flush cycle, and an issue attempted in that cycle is dropped.
- R10: After reset the buffer is empty: iss_ready is high, iss_tag is 0, and rf_we, mem_we and flush are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue request |
| iss_kind | input | 2 | 0 ordinary, 1 store, 2 branch |
| iss_dest | input | AW | Destination register of an ordinary instruction |
| iss_src_ok | input | 1 | Store data already available at issue |
| iss_src_tag | input | TW | Tag of the instruction producing the store data |
| iss_src_val | input | XW | Store data when iss_src_ok is high |
| iss_ready | output | 1 | A slot is free and no flush is under way |
| iss_tag | output | TW | Tag that the next accepted issue receives |
| cdb_valid | input | 1 | Result bus broadcast valid |
| cdb_tag | input | TW | Tag of the broadcast result |
| cdb_value | input | XW | Result, store address or branch target |
| cdb_mispred | input | 1 | Branch outcome was mispredicted |
| rf_we | output | 1 | Register file write strobe |
| rf_idx | output | AW | Register index |
| rf_data | output | XW | Register write data |
| mem_we | output | 1 | Memory store strobe |
| mem_addr | output | XW | Store address |
| mem_data | output | XW | Store data |
| flush | output | 1 | Discard all speculative state |
| redirect_pc | output | XW | Restart address during flush |

## Verification
The bound checker watches several properties on every cycle:
- The three retirement strobes never overlap.
- iss_ready stays low while the buffer is full and during a flush.
- Accepted issue tags advance with wrap-around.
- The buffer is empty right after a flush.
- Nothing retires from an empty buffer.

Other behaviours depend on data values and ordering, so only the bench scenarios can show them. These are:
- Out-of-order completion retiring in program order with the right register and value.
- The three ways a store gets its data.
- Broadcasts to free slots leaving no trace.
- A correct branch retiring silently.
- Younger work vanishing after a misprediction.

// File: rtl/rob_pkg.sv
package rob_pkg;

    typedef enum logic [1:0] {
        OP_ALU    = 2'd0,
        OP_STORE  = 2'd1,
        OP_BRANCH = 2'd2,
        OP_RSVD   = 2'd3
    } op_kind_e;

endpackage

// File: rtl/rob_cdb_snoop.sv
module rob_cdb_snoop
    import rob_pkg::*;
#(
    parameter int TW     = 3,
    parameter int MY_TAG = 0
) (
    input  logic          slot_valid,
    input  op_kind_e      slot_kind,
    input  logic          slot_done,
    input  logic          slot_sd_ok,
    input  logic [TW-1:0] slot_sd_tag,
    input  logic          cdb_valid,
    input  logic [TW-1:0] cdb_tag,
    output logic          hit_result,
    output logic          hit_sdata
);
    // own-tag match fills the result field
    assign hit_result = slot_valid && !slot_done && cdb_valid
                        && (cdb_tag == TW'(MY_TAG));
    // a waiting store grabs its data when the producer tag appears
    assign hit_sdata  = slot_valid && (slot_kind == OP_STORE) && !slot_sd_ok
                        && cdb_valid && (cdb_tag == slot_sd_tag);
endmodule

// File: rtl/rob_retire_sel.sv
module rob_retire_sel
    import rob_pkg::*;
#(
    parameter int AW = 5,
    parameter int XW = 32
) (
    input  logic          head_valid,
    input  op_kind_e      head_kind,
    input  logic          head_done,
    input  logic          head_mispred,
    input  logic          head_sd_ok,
    input  logic [AW-1:0] head_dest,
    input  logic [XW-1:0] head_val,
    input  logic [XW-1:0] head_sdata,
    output logic          retire,
    output logic          rf_we,
    output logic [AW-1:0] rf_idx,
    output logic [XW-1:0] rf_data,
    output logic          mem_we,
    output logic [XW-1:0] mem_addr,
    output logic [XW-1:0] mem_data,
    output logic          flush,
    output logic [XW-1:0] redirect_pc
);
    always_comb begin
        retire      = head_valid && head_done
                      && ((head_kind != OP_STORE) || head_sd_ok);
        rf_we       = retire && (head_kind == OP_ALU);
        mem_we      = retire && (head_kind == OP_STORE);
        flush       = retire && (head_kind == OP_BRANCH) && head_mispred;
        rf_idx      = head_dest;
        rf_data     = head_val;
        mem_addr    = head_val;
        mem_data    = head_sdata;
        redirect_pc = head_val;
    end
endmodule

// File: rtl/rob_core.sv
module rob_core
    import rob_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 5,
    parameter int XW    = 32,
    localparam int TW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iss_valid,
    input  logic [1:0]    iss_kind,
    input  logic [AW-1:0] iss_dest,
    input  logic          iss_src_ok,
    input  logic [TW-1:0] iss_src_tag,
    input  logic [XW-1:0] iss_src_val,
    output logic          iss_ready,
    output logic [TW-1:0] iss_tag,
    input  logic          cdb_valid,
    input  logic [TW-1:0] cdb_tag,
    input  logic [XW-1:0] cdb_value,
    input  logic          cdb_mispred,
    output logic          rf_we,
    output logic [AW-1:0] rf_idx,
    output logic [XW-1:0] rf_data,
    output logic          mem_we,
    output logic [XW-1:0] mem_addr,
    output logic [XW-1:0] mem_data,
    output logic          flush,
    output logic [XW-1:0] redirect_pc
);

    typedef struct packed {
        logic          valid;
        op_kind_e      kind;
        logic          done;
        logic          mispred;
        logic [AW-1:0] dest;
        logic [XW-1:0] val;
        logic          sd_ok;
        logic [TW-1:0] sd_tag;
        logic [XW-1:0] sdata;
    } slot_t;

    typedef struct packed {
        slot_t [DEPTH-1:0] slot;
        logic  [TW-1:0]    head;
        logic  [TW-1:0]    tail;
        logic  [CW-1:0]    count;
    } state_t;

    state_t st_d, st_q;

    logic [DEPTH-1:0] hit_res, hit_sd;
    logic             retire;
    logic             issue_fire;
    logic [CW-1:0]    occupancy;

    function automatic logic [TW-1:0] wrap_inc(input logic [TW-1:0] p);
        return (p == TW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    for (genvar g = 0; g < DEPTH; g++) begin : g_snoop
        rob_cdb_snoop #(.TW(TW), .MY_TAG(g)) u_snoop (
            .slot_valid (st_q.slot[g].valid),
            .slot_kind  (st_q.slot[g].kind),
            .slot_done  (st_q.slot[g].done),
            .slot_sd_ok (st_q.slot[g].sd_ok),
            .slot_sd_tag(st_q.slot[g].sd_tag),
            .cdb_valid  (cdb_valid),
            .cdb_tag    (cdb_tag),
            .hit_result (hit_res[g]),
            .hit_sdata  (hit_sd[g])
        );
    end

    rob_retire_sel #(.AW(AW), .XW(XW)) u_retire (
        .head_valid  (st_q.slot[st_q.head].valid),
        .head_kind   (st_q.slot[st_q.head].kind),
        .head_done   (st_q.slot[st_q.head].done),
        .head_mispred(st_q.slot[st_q.head].mispred),
        .head_sd_ok  (st_q.slot[st_q.head].sd_ok),
        .head_dest   (st_q.slot[st_q.head].dest),
        .head_val    (st_q.slot[st_q.head].val),
        .head_sdata  (st_q.slot[st_q.head].sdata),
        .retire      (retire),
        .rf_we       (rf_we),
        .rf_idx      (rf_idx),
        .rf_data     (rf_data),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_data    (mem_data),
        .flush       (flush),
        .redirect_pc (redirect_pc)
    );

    assign iss_ready  = (st_q.count != CW'(DEPTH)) && !flush;
    assign iss_tag    = st_q.tail;
    assign issue_fire = iss_valid && iss_ready;
    assign occupancy  = st_q.count;

    always_comb begin
        st_d = st_q;

        // result bus capture
        for (int i = 0; i < DEPTH; i++) begin
            if (hit_res[i]) begin
                st_d.slot[i].done    = 1'b1;
                st_d.slot[i].val     = cdb_value;
                st_d.slot[i].mispred = cdb_mispred;
            end
            if (hit_sd[i]) begin
                st_d.slot[i].sd_ok = 1'b1;
                st_d.slot[i].sdata = cdb_value;
            end
        end

        // retirement of the oldest slot
        if (flush) begin
            for (int i = 0; i < DEPTH; i++) begin
                st_d.slot[i].valid = 1'b0;
            end
            st_d.head  = '0;
            st_d.tail  = '0;
            st_d.count = '0;
        end else begin
            if (retire) begin
                st_d.slot[st_q.head].valid = 1'b0;
                st_d.head = wrap_inc(st_q.head);
            end
            // allocation at the tail
            if (issue_fire) begin
                st_d.slot[st_q.tail].valid   = 1'b1;
                st_d.slot[st_q.tail].kind    = op_kind_e'(iss_kind);
                st_d.slot[st_q.tail].done    = 1'b0;
                st_d.slot[st_q.tail].mispred = 1'b0;
                st_d.slot[st_q.tail].dest    = iss_dest;
                st_d.slot[st_q.tail].val     = '0;
                st_d.slot[st_q.tail].sd_tag  = iss_src_tag;
                if (op_kind_e'(iss_kind) != OP_STORE) begin
                    st_d.slot[st_q.tail].sd_ok = 1'b1;
                    st_d.slot[st_q.tail].sdata = '0;
                end else if (iss_src_ok) begin
                    st_d.slot[st_q.tail].sd_ok = 1'b1;
                    st_d.slot[st_q.tail].sdata = iss_src_val;
                end else if (cdb_valid && cdb_tag == iss_src_tag) begin
                    st_d.slot[st_q.tail].sd_ok = 1'b1;
                    st_d.slot[st_q.tail].sdata = cdb_value;
                end else begin
                    st_d.slot[st_q.tail].sd_ok = 1'b0;
                    st_d.slot[st_q.tail].sdata = '0;
                end
                st_d.tail = wrap_inc(st_q.tail);
            end
            st_d.count = st_q.count + CW'(issue_fire) - CW'(retire);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
    parameter int DEPTH = 8,
    localparam int TW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          iss_valid,
    input logic          iss_ready,
    input logic [TW-1:0] iss_tag,
    input logic          rf_we,
    input logic          mem_we,
    input logic          flush,
    input logic [CW-1:0] occupancy
);
    // R1
    tag_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready) |=> iss_tag ==
            (($past(iss_tag) == TW'(DEPTH - 1)) ? '0 : $past(iss_tag) + 1'b1));

    // R2
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occupancy == CW'(DEPTH)) |-> !iss_ready);

    // R5
    empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occupancy == '0) |-> !(rf_we || mem_we || flush));

    // R6
    one_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rf_we, mem_we, flush}));

    // R8
    flush_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (occupancy == '0) && (iss_tag == '0));

    // R9
    flush_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !iss_ready);
endmodule

bind rob_core rob_core_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .iss_valid(iss_valid),
    .iss_ready(iss_ready),
    .iss_tag  (iss_tag),
    .rf_we    (rf_we),
    .mem_we   (mem_we),
    .flush    (flush),
    .occupancy(occupancy)
);

// File: tb/rob_core_test.sv
module rob_core_test;
    localparam int DEPTH = 8;
    localparam int AW    = 5;
    localparam int XW    = 32;
    localparam int TW    = $clog2(DEPTH);

    localparam logic [AW-1:0] VDEST [DEPTH] = '{5'd1, 5'd2, 5'd3, 5'd4, 5'd10, 5'd17, 5'd30, 5'd31};
    localparam logic [XW-1:0] VVAL  [DEPTH] = '{32'h0000_0011, 32'h1234_5678, 32'hFFFF_FFFF, 32'h0,
                                               32'h8000_0001, 32'h00AB_CDEF, 32'h7FFF_0000, 32'h5A5A_A5A5};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          iss_valid = 1'b0;
    logic [1:0]    iss_kind = 2'd0;
    logic [AW-1:0] iss_dest = '0;
    logic          iss_src_ok = 1'b0;
    logic [TW-1:0] iss_src_tag = '0;
    logic [XW-1:0] iss_src_val = '0;
    logic          iss_ready;
    logic [TW-1:0] iss_tag;
    logic          cdb_valid = 1'b0;
    logic [TW-1:0] cdb_tag = '0;
    logic [XW-1:0] cdb_value = '0;
    logic          cdb_mispred = 1'b0;
    logic          rf_we;
    logic [AW-1:0] rf_idx;
    logic [XW-1:0] rf_data;
    logic          mem_we;
    logic [XW-1:0] mem_addr;
    logic [XW-1:0] mem_data;
    logic          flush;
    logic [XW-1:0] redirect_pc;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    rob_core #(.DEPTH(DEPTH), .AW(AW), .XW(XW)) uut (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_kind(iss_kind), .iss_dest(iss_dest),
        .iss_src_ok(iss_src_ok), .iss_src_tag(iss_src_tag), .iss_src_val(iss_src_val),
        .iss_ready(iss_ready), .iss_tag(iss_tag),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value), .cdb_mispred(cdb_mispred),
        .rf_we(rf_we), .rf_idx(rf_idx), .rf_data(rf_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
        .flush(flush), .redirect_pc(redirect_pc)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        iss_valid = 1'b0;
        cdb_valid = 1'b0;
        cdb_mispred = 1'b0;
    endtask

    task automatic issue(input logic [1:0] kind, input logic [AW-1:0] dest,
                         input logic src_ok, input logic [TW-1:0] src_tag, input logic [XW-1:0] src_val);
        iss_valid   = 1'b1;
        iss_kind    = kind;
        iss_dest    = dest;
        iss_src_ok  = src_ok;
        iss_src_tag = src_tag;
        iss_src_val = src_val;
    endtask

    task automatic bcast(input logic [TW-1:0] tag, input logic [XW-1:0] val, input logic mp);
        cdb_valid   = 1'b1;
        cdb_tag     = tag;
        cdb_value   = val;
        cdb_mispred = mp;
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        // R10 reset state
        chk("R10 ready", iss_ready, 1);
        chk("R10 tag", iss_tag, 0);
        chk("R10 rf_we", rf_we, 0);
        chk("R10 mem_we", mem_we, 0);
        chk("R10 flush", flush, 0);

        // vector table: fill, complete out of order, retire in order
        for (int i = 0; i < DEPTH; i++) begin
            issue(2'd0, VDEST[i], 1'b0, '0, '0);
            chk("R1 tag order", iss_tag, i);
            chk("R2 ready while not full", iss_ready, 1);
            tick();
        end
        idle();
        chk("R2 full stall", iss_ready, 0);
        for (int k = DEPTH - 1; k >= 1; k--) begin
            bcast(TW'(k), VVAL[k], 1'b0);
            tick();
            idle();
            chk("R5 younger waits", rf_we, 0);
        end
        bcast('0, VVAL[0], 1'b0);
        tick();
        idle();
        for (int i = 0; i < DEPTH; i++) begin
            chk("R6 rf_we", rf_we, 1);
            chk("R6 rf_idx", rf_idx, VDEST[i]);
            chk("R6 rf_data", rf_data, VVAL[i]);
            if (i == 0) chk("R2 still full in retire cycle", iss_ready, 0);
            tick();
            if (i == 0) chk("R2 ready after retire", iss_ready, 1);
        end
        chk("R5 empty no retire", rf_we, 0);
        chk("R1 wrap to 0", iss_tag, 0);

        // R3 broadcast to a free slot leaves no trace
        bcast('0, 32'hDEAD, 1'b0);
        tick();
        idle();
        issue(2'd0, 5'd9, 1'b0, '0, '0);
        tick();
        idle();
        chk("R3 stale broadcast ignored", rf_we, 0);
        tick();
        chk("R3 still incomplete", rf_we, 0);
        bcast('0, 32'h1234, 1'b0);
        tick();
        idle();
        chk("R3 capture rf_we", rf_we, 1);
        chk("R3 capture data", rf_data, 32'h1234);
        chk("R3 capture idx", rf_idx, 9);
        tick();

        // R4 store data arriving after address
        issue(2'd0, 5'd3, 1'b0, '0, '0);        // tag 1
        tick();
        issue(2'd1, 5'd0, 1'b0, 3'd1, '0);      // store tag 2, data from tag 1
        tick();
        idle();
        bcast(3'd2, 32'h100, 1'b0);
        tick();
        idle();
        chk("R4 store waits for data", mem_we, 0);
        bcast(3'd1, 32'hCAFE, 1'b0);
        tick();
        idle();
        chk("R6 producer retires", rf_we, 1);
        chk("R6 producer data", rf_data, 32'hCAFE);
        tick();
        chk("R4 late store mem_we", mem_we, 1);
        chk("R4 late store addr", mem_addr, 32'h100);
        chk("R4 late store data", mem_data, 32'hCAFE);
        chk("R6 store no rf_we", rf_we, 0);
        tick();

        // R4 data broadcast in the issue cycle of the store
        issue(2'd0, 5'd4, 1'b0, '0, '0);        // tag 3
        tick();
        issue(2'd1, 5'd0, 1'b0, 3'd3, '0);      // store tag 4
        bcast(3'd3, 32'hBEEF, 1'b0);
        tick();
        idle();
        bcast(3'd4, 32'h200, 1'b0);
        chk("R6 tag3 retires", rf_data, 32'hBEEF);
        tick();
        idle();
        chk("R4 forwarded mem_we", mem_we, 1);
        chk("R4 forwarded addr", mem_addr, 32'h200);
        chk("R4 forwarded data", mem_data, 32'hBEEF);
        tick();

        // R4 data ready at issue
        issue(2'd1, 5'd0, 1'b1, 3'd0, 32'h55);  // tag 5
        tick();
        idle();
        bcast(3'd5, 32'h300, 1'b0);
        tick();
        idle();
        chk("R4 ready-data mem_we", mem_we, 1);
        chk("R4 ready-data data", mem_data, 32'h55);
        chk("R4 ready-data addr", mem_addr, 32'h300);
        tick();

        // R7 correctly predicted branch
        issue(2'd2, 5'd0, 1'b0, '0, '0);        // tag 6
        tick();
        issue(2'd0, 5'd7, 1'b0, '0, '0);        // tag 7
        tick();
        idle();
        bcast(3'd7, 32'h77, 1'b0);
        tick();
        bcast(3'd6, 32'h999, 1'b0);
        tick();
        idle();
        chk("R7 branch rf_we", rf_we, 0);
        chk("R7 branch mem_we", mem_we, 0);
        chk("R7 branch flush", flush, 0);
        tick();
        chk("R7 next retires rf_we", rf_we, 1);
        chk("R7 next retires data", rf_data, 32'h77);
        tick();

        // R8 / R9 mispredicted branch
        issue(2'd0, 5'd1, 1'b0, '0, '0);        // tag 0
        tick();
        issue(2'd2, 5'd0, 1'b0, '0, '0);        // tag 1
        tick();
        issue(2'd0, 5'd2, 1'b0, '0, '0);        // tag 2
        tick();
        idle();
        bcast(3'd2, 32'h22, 1'b0);
        tick();
        bcast(3'd0, 32'h11, 1'b0);
        tick();
        bcast(3'd1, 32'h400, 1'b1);
        chk("R6 tag0 retires", rf_data, 32'h11);
        tick();
        idle();
        chk("R8 flush", flush, 1);
        chk("R8 redirect", redirect_pc, 32'h400);
        chk("R9 ready low in flush", iss_ready, 0);
        issue(2'd0, 5'd5, 1'b0, '0, '0);        // must be dropped
        tick();
        idle();
        chk("R8 flush one cycle", flush, 0);
        chk("R8 younger discarded", rf_we, 0);
        chk("R8 tag restart", iss_tag, 0);
        chk("R9 ready after flush", iss_ready, 1);
        tick();
        chk("R9 dropped issue absent", rf_we, 0);
        issue(2'd0, 5'd6, 1'b0, '0, '0);
        chk("R8 new issue tag 0", iss_tag, 0);
        tick();
        idle();
        bcast('0, 32'h66, 1'b0);
        tick();
        idle();
        chk("R8 post-flush retire", rf_we, 1);
        chk("R8 post-flush idx", rf_idx, 6);
        tick();
        chk("R9 no ghost entry", rf_we, 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule